// File: doc/BRIEF.md
# Six-Bit Bidirectional GPIO Port with Analog Gating

This block is a register-mapped general-purpose I/O port of six pins for a small microcontroller core. Each pin has a bit in an output data latch and a bit in a direction register. Direction 1 turns the pin's driver off. Direction 0 drives the pin from its latch bit. A port read returns the synchronized levels seen on the pins, not the latch. Every port modification works from those pin levels. A single-bit set or clear therefore samples all six pins, changes one bit and writes the whole result back into the latch.

Pin 4 is open-drain and is never driven high. Its synchronized level also goes out as a clock tap for a timer. Pins 0 to 3 and 5 can be placed in analog mode by an analog-configuration register. A pin in analog mode has its digital input read as 0. Only the value 0x06 in that register makes every pin digital. After reset, the pins start in analog mode as inputs with the latch cleared.

The core accesses the port with a two-bit register select, a full-write strobe, bit-set and bit-clear strobes with a bit index, and a combinational read-data mux. The register select encoding is 0 = data port, 1 = direction, 2 = analog configuration (write-only), 3 = unused.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction register reads 0x3F, the latch is 0 so that pin_out reads 0x00, pin_oe is 0x00, and the analog configuration is 0x00, which puts pins 0-3 and 5 in analog mode.
- R2: A pin whose direction bit is 1 has pin_oe low. A pin other than bit 4 whose direction bit is 0 has pin_oe high and pin_out equal to its latch bit.
- R3: A read with select 0 returns in bits 5:0 the pin levels after a two-flop synchronizer, and 0 in bits 7:6. A full write with select 0 loads wdata[5:0] into the latch and does not change what a port read returns.
- R4: pin_out[4] is always 0. pin_oe[4] is high only when direction bit 4 is 0 and latch bit 4 is 0.
- R5: A bit set or bit clear with select 0 loads the latch with the current port read value, with bit bus_bit forced to 1 (set) or 0 (clear). For bus_bit of 6 or 7, the latch takes the port read value unchanged.
- R6: When the analog configuration differs from 0x06, port read bits 0-3 and 5 are 0, and bit 4 still shows its pin. When it equals 0x06, all six bits show their pins. Bit operations in analog mode copy those 0 bits into the latch.
- R7: A read with select 1 returns the direction register in bits 5:0 and 0 in bits 7:6. A full write, bit set or bit clear with select 1 updates the direction register, and the bit operations start from its stored value.
- R8: tmr_clk equals the synchronized level of pin 4, independent of analog mode and of direction.
- R9: When a full write and a bit operation arrive in the same cycle, only the full write takes effect. A bit set wins over a bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 2 | Register select: 0 data, 1 direction, 2 analog config |
| bus_wr | input | 1 | Full-write strobe |
| bus_bset | input | 1 | Bit-set strobe |
| bus_bclr | input | 1 | Bit-clear strobe |
| bus_bit | input | 3 | Bit index for set/clear |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 6 | Pin levels from the pads |
| pin_out | output | 6 | Output value to the pads |
| pin_oe | output | 6 | Per-pin driver enable |
| tmr_clk | output | 1 | Synchronized pin-4 level for the timer |

## Verification
The port is tested with alternating pin patterns (0x2A, 0x15) so that a swapped or stuck read bit shows up. The bench also writes latch values that differ from the pins, which separates pin read-back from latch read-back. Bit set and clear are run with input pins held at values that differ from the latch, so a design that modifies the latch instead of the pins gives a different pin_out. Analog configurations 0x00, 0x01, 0x07 and 0x06 show whether the gate decodes only the single digital value and leaves bit 4 alone. Simultaneous strobes and an out-of-range bit index cover the priority and boundary rules.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W     = 6;
    localparam int BUS_W      = 8;
    localparam int BIT_IDX_W  = 3;
    localparam int OD_BIT     = 4;
    localparam logic [PORT_W-1:0] ANALOG_PINS = 6'b101111;
    localparam logic [BUS_W-1:0]  DIGITAL_CFG = 8'h06;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_ACFG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] lat;
        logic [PORT_W-1:0] dir;
        logic [BUS_W-1:0]  acfg;
    } port_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_d, meta_q, sync_d, sync_q;

    always_comb begin
        meta_d = d;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int PW = PORT_W,
    parameter int DW = BUS_W,
    parameter int BW = BIT_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  reg_sel_e      sel,
    input  logic          wr,
    input  logic          bset,
    input  logic          bclr,
    input  logic [BW-1:0] bit_idx,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] pin_rd,
    output logic [PW-1:0] lat_q,
    output logic [PW-1:0] dir_q,
    output logic          digital
);
    port_state_t st_d, st_q;
    logic [PW-1:0] bit_mask;
    logic [PW-1:0] base;
    logic [PW-1:0] modified;

    always_comb begin
        bit_mask = '0;
        for (int i = 0; i < PW; i++) begin
            if (int'(bit_idx) == i) bit_mask[i] = 1'b1;
        end
        base     = (sel == SEL_DIR) ? st_q.dir : pin_rd;
        modified = bset ? (base | bit_mask) : (base & ~bit_mask);

        st_d = st_q;
        if (wr) begin
            case (sel)
                SEL_DATA: st_d.lat  = wdata[PW-1:0];
                SEL_DIR:  st_d.dir  = wdata[PW-1:0];
                SEL_ACFG: st_d.acfg = wdata;
                default:  st_d      = st_q;
            endcase
        end else if (bset || bclr) begin
            case (sel)
                SEL_DATA: st_d.lat = modified;
                SEL_DIR:  st_d.dir = modified;
                default:  st_d     = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat  <= '0;
            st_q.dir  <= '1;
            st_q.acfg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_q   = st_q.lat;
    assign dir_q   = st_q.dir;
    assign digital = (st_q.acfg == DIGITAL_CFG);

    AST_DIR_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DIR) |=> (dir_q == $past(wdata[PW-1:0]))); // R7
    AST_WR_OVER_BITOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DATA) |=> (lat_q == $past(wdata[PW-1:0]))); // R9
    AST_BSET_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bset && !wr && sel == SEL_DATA && int'(bit_idx) < PW)
        |=> lat_q[$past(bit_idx)]); // R5
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_pkg::*;
#(
    parameter int                PW   = PORT_W,
    parameter int                ODB  = OD_BIT,
    parameter logic [PW-1:0]     AMSK = ANALOG_PINS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] lat,
    input  logic [PW-1:0] dir,
    input  logic [PW-1:0] pin_sync,
    input  logic          digital,
    output logic [PW-1:0] pin_oe,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_rd,
    output logic          tmr_clk
);
    for (genvar i = 0; i < PW; i++) begin : g_pin
        if (i == ODB) begin : g_od
            assign pin_out[i] = 1'b0;
            assign pin_oe[i]  = ~dir[i] & ~lat[i];
            assign pin_rd[i]  = pin_sync[i];
            AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                pin_oe[i] |-> !pin_out[i]); // R4
        end else begin : g_pp
            assign pin_out[i] = lat[i];
            assign pin_oe[i]  = ~dir[i];
            assign pin_rd[i]  = (AMSK[i] && !digital) ? 1'b0 : pin_sync[i];
        end
        AST_INPUT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
            dir[i] |-> !pin_oe[i]); // R2
    end

    assign tmr_clk = pin_sync[ODB];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int PW = PORT_W,
    parameter int DW = BUS_W,
    parameter int BW = BIT_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_sel,
    input  logic          bus_wr,
    input  logic          bus_bset,
    input  logic          bus_bclr,
    input  logic [BW-1:0] bus_bit,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [PW-1:0] pin_in,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_oe,
    output logic          tmr_clk
);
    localparam int PAD_W = DW - PW;

    reg_sel_e      sel;
    logic [PW-1:0] pin_sync, pin_rd, lat_q, dir_q;
    logic          digital;

    assign sel = reg_sel_e'(bus_sel);

    gpio_sync #(.W(PW)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_regs #(.PW(PW), .DW(DW), .BW(BW)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(bus_wr), .bset(bus_bset),
        .bclr(bus_bclr), .bit_idx(bus_bit), .wdata(bus_wdata), .pin_rd(pin_rd),
        .lat_q(lat_q), .dir_q(dir_q), .digital(digital)
    );

    gpio_pad_ctl #(.PW(PW)) u_pad (
        .clk(clk), .rst_n(rst_n), .lat(lat_q), .dir(dir_q), .pin_sync(pin_sync),
        .digital(digital), .pin_oe(pin_oe), .pin_out(pin_out), .pin_rd(pin_rd),
        .tmr_clk(tmr_clk)
    );

    always_comb begin
        case (sel)
            SEL_DATA: bus_rdata = {{PAD_W{1'b0}}, pin_rd};
            SEL_DIR:  bus_rdata = {{PAD_W{1'b0}}, dir_q};
            default:  bus_rdata = '0;
        endcase
    end

    AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:PW] == '0); // R3
    AST_ANALOG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!digital && sel == SEL_DATA) |-> ((bus_rdata[PW-1:0] & ANALOG_PINS) == '0)); // R6
    AST_TMR_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clk == pin_sync[OD_BIT]); // R8
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] bus_sel = 0;
    logic       bus_wr = 0, bus_bset = 0, bus_bclr = 0;
    logic [2:0] bus_bit = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [5:0] pin_in = 0;
    logic [5:0] pin_out, pin_oe;
    logic       tmr_clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        int         kind;
        logic [7:0] exp;
    } item_t;
    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_bset(bus_bset), .bus_bclr(bus_bclr), .bus_bit(bus_bit),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .tmr_clk(tmr_clk)
    );

    // monitor: pop and compare away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sbq.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {2'b00, pin_oe};
                    2: act = {2'b00, pin_out};
                    default: act = {7'b0, tmr_clk};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bitop(input logic [1:0] s, input bit set, input logic [2:0] b);
        @(negedge clk);
        bus_sel = s; bus_bit = b; bus_bset = set; bus_bclr = !set;
        @(negedge clk);
        bus_bset = 0; bus_bclr = 0;
    endtask

    task automatic pins(input logic [5:0] v);
        @(negedge clk);
        pin_in = v;
        idle(3);
    endtask

    // kind 0 = rdata at select s, 1 = pin_oe, 2 = pin_out, 3 = tmr_clk
    task automatic expect_item(input string tag, input int kind,
                               input logic [1:0] s, input logic [7:0] e);
        item_t it;
        @(negedge clk);
        bus_sel = s;
        it.tag = tag; it.kind = kind; it.exp = e;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        expect_item("R1 dir reset", 0, 2'd1, 8'h3F);
        expect_item("R1 oe reset", 1, 2'd0, 8'h00);
        expect_item("R1 out reset", 2, 2'd0, 8'h00);
        pins(6'h3F);
        expect_item("R1 analog after reset", 0, 2'd0, 8'h10);
        // R3 read of pins in digital mode
        wr(2'd2, 8'h06);
        pins(6'h2A);
        expect_item("R3 read 0x2A", 0, 2'd0, 8'h2A);
        pins(6'h15);
        expect_item("R3 read 0x15", 0, 2'd0, 8'h15);
        wr(2'd0, 8'hFF);
        expect_item("R3 latch write not read back", 0, 2'd0, 8'h15);
        // R2 / R4 drivers
        wr(2'd1, 8'h00);
        expect_item("R2 R4 oe latch4=1", 1, 2'd0, 8'h2F);
        expect_item("R2 R4 out", 2, 2'd0, 8'h2F);
        wr(2'd0, 8'h00);
        expect_item("R4 oe latch4=0", 1, 2'd0, 8'h3F);
        // R7 direction readback and bit ops
        expect_item("R7 dir 0x00", 0, 2'd1, 8'h00);
        bitop(2'd1, 1, 3'd3);
        expect_item("R7 dir bset3", 0, 2'd1, 8'h08);
        expect_item("R2 oe with dir3 input", 1, 2'd0, 8'h37);
        wr(2'd1, 8'hFF);
        expect_item("R7 dir write 0xFF", 0, 2'd1, 8'h3F);
        bitop(2'd1, 0, 3'd5);
        expect_item("R7 dir bclr5", 0, 2'd1, 8'h1F);
        // R5 read-modify-write from pins
        wr(2'd1, 8'h3F);
        pins(6'h21);
        bitop(2'd0, 1, 3'd1);
        wr(2'd1, 8'h00);
        expect_item("R5 bset copies pins", 2, 2'd0, 8'h23);
        wr(2'd1, 8'h3F);
        pins(6'h3D);
        bitop(2'd0, 0, 3'd0);
        wr(2'd1, 8'h00);
        expect_item("R5 bclr copies pins", 2, 2'd0, 8'h2C);
        expect_item("R5 R4 oe after bclr", 1, 2'd0, 8'h2F);
        pins(6'h05);
        bitop(2'd0, 1, 3'd7);
        expect_item("R5 out-of-range bit", 2, 2'd0, 8'h05);
        // R6 analog gating
        pins(6'h3F);
        wr(2'd2, 8'h00);
        expect_item("R6 cfg 0x00", 0, 2'd0, 8'h10);
        wr(2'd2, 8'h07);
        expect_item("R6 cfg 0x07", 0, 2'd0, 8'h10);
        wr(2'd2, 8'h06);
        expect_item("R6 cfg 0x06", 0, 2'd0, 8'h3F);
        wr(2'd2, 8'h01);
        bitop(2'd0, 1, 3'd2);
        expect_item("R6 analog bitop", 2, 2'd0, 8'h04);
        // R8 timer tap in analog mode with dir output
        expect_item("R8 tmr high", 3, 2'd0, 8'h01);
        pins(6'h2F);
        expect_item("R8 tmr low", 3, 2'd0, 8'h00);
        // R9 priority
        @(negedge clk);
        bus_sel = 2'd0; bus_wdata = 8'h2A; bus_wr = 1; bus_bset = 1; bus_bit = 3'd0;
        @(negedge clk);
        bus_wr = 0; bus_bset = 0;
        expect_item("R9 full write wins", 2, 2'd0, 8'h2A);
        @(negedge clk);
        bus_sel = 2'd1; bus_bit = 3'd2; bus_bset = 1; bus_bclr = 1;
        @(negedge clk);
        bus_bset = 0; bus_bclr = 0;
        expect_item("R9 set over clear", 0, 2'd1, 8'h04);
        idle(3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule